// File: doc/BRIEF.md
# Strobed Handshake Port Controller

This block is one 8-bit parallel port that moves data between a processor and a peripheral under a strobed handshake. Its direction is fixed when the design is elaborated. As an input port, the peripheral pulses a low strobe to load a byte into a read latch. The port then raises a buffer-full flag. An interrupt request follows once the strobe has returned high. As an output port, a processor write loads an output latch and asserts an active-low output-buffer-full line toward the peripheral. The peripheral answers with a low acknowledge. The interrupt request is raised when that acknowledge has gone high again.

The peripheral strobe and acknowledge are asynchronous. They pass through a synchronizer before their edges are detected in the system clock domain. The processor read and write strobes are synchronous, active low, and acted on at their edges. A software-loaded enable bit masks the interrupt. A strobed-mode enable holds the port idle while low. While it is low, every flag is inactive and all strobes are ignored.

Top module: `hsk_port`

## Requirements
- R1: After reset the buffer-full flag is low, the active-low output-buffer-full line is high, the interrupt is low, the read and output latches hold zero, and the interrupt enable is clear.
- R2: Input direction: while the synchronized strobe is low, the read latch takes the peripheral data, delayed by the same number of stages as the strobe. The buffer-full flag rises on the third clock edge after a falling strobe at the pin, and the latch holds once the strobe is back high.
- R3: Input direction: the buffer-full flag clears on the clock edge after a rising CPU read (read pin low on one edge, high the next). If a synchronized strobe fall arrives in the same cycle, the flag stays set.
- R4: Input direction: the interrupt equals enable AND buffer full AND synchronized strobe high AND registered read high. It therefore rises two edges after the strobe returns high, and drops one edge after the read goes low.
- R5: Output direction: while the write pin is low, the output latch loads the CPU write data and drives it on the peripheral data pins one edge later. A rising write drives the output-buffer-full line low on the next edge.
- R6: Output direction: a synchronized falling acknowledge returns the output-buffer-full line high, three edges after the pin falls. If it coincides with a rising write, the line goes low.
- R7: Output direction: the interrupt equals enable AND output-buffer-full line high AND synchronized acknowledge high AND registered write high.
- R8: A write-enable pulse loads the interrupt enable bit. When a zero is loaded, the interrupt is low from the next clock edge onward.
- R9: With strobed mode off, buffer-full is low, the output-buffer-full line is high, the interrupt is low, and strobes and CPU writes leave both latches untouched. On entry to strobed mode the output-buffer-full line stays high.
- R10: In input direction the peripheral output pins are zero and the output-buffer-full line is high. In output direction the buffer-full flag is low. In output direction the CPU read data returns the output latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Strobed mode enable |
| ie_we_i | input | 1 | Load strobe for the interrupt enable |
| ie_i | input | 1 | Interrupt enable value |
| rd_ni | input | 1 | CPU read strobe, active low |
| wr_ni | input | 1 | CPU write strobe, active low |
| wdata_i | input | DW | CPU write data |
| rdata_o | output | DW | CPU read data (read latch or output latch) |
| pdat_i | input | DW | Peripheral data in |
| pdat_o | output | DW | Peripheral data out |
| stb_ni | input | 1 | Peripheral strobe, active low, asynchronous |
| ack_ni | input | 1 | Peripheral acknowledge, active low, asynchronous |
| ibf_o | output | 1 | Input buffer full |
| obf_no | output | 1 | Output buffer full, active low |
| intr_o | output | 1 | Interrupt request |

## Verification
Results driven by the CPU strobes and the enable write are due one clock edge after the input changes. The mode input adds one edge, because mode is registered. Results driven by the strobe or acknowledge pins are due three edges after a fall and two edges after a rise. The bench drives on falling clock edges. The vector table holds each step for four cycles before it samples, so every result has settled. Directed tests then sample on the exact edges that bound each latency: one edge early, where the old value must still show, and on the due edge. They also line a synchronized peripheral edge up with a CPU strobe edge in the same cycle to check the priority rules.

// File: rtl/hsk_pkg.sv
package hsk_pkg;
  typedef enum logic {DIR_IN = 1'b0, DIR_OUT = 1'b1} port_dir_e;
  localparam int unsigned MIN_SYNC = 2;
endpackage

// File: rtl/hsk_sync.sv
module hsk_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic lvl_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     chain_q[g] <= RST_VAL;
      else if (g == 0) chain_q[g] <= async_i;
      else             chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= chain_q[STAGES-1];
  end

  assign lvl_o  = chain_q[STAGES-1];
  assign fall_o = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/hsk_in_path.sv
module hsk_in_path #(
  parameter int unsigned DW     = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_i,
  input  logic          ie_i,
  input  logic          stb_ni,
  input  logic          rd_ni,
  input  logic [DW-1:0] pdat_i,
  output logic          ibf_o,
  output logic          intr_o,
  output logic [DW-1:0] rdata_o
);
  logic          stb_s, stb_fall;
  logic          rd_q, rd_rise;
  logic          ibf_q;
  logic [DW-1:0] data_q;
  logic [DW-1:0] dpipe_q [STAGES];

  hsk_sync #(.STAGES(STAGES), .RST_VAL(1'b1)) u_stb_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(stb_ni),
    .lvl_o  (stb_s),
    .fall_o (stb_fall)
  );

  // data delayed to line up with the synchronized strobe
  for (genvar g = 0; g < STAGES; g++) begin : g_dpipe
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     dpipe_q[g] <= '0;
      else if (g == 0) dpipe_q[g] <= pdat_i;
      else             dpipe_q[g] <= dpipe_q[(g == 0) ? 0 : g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= 1'b1;
    else         rd_q <= rd_ni;
  end
  assign rd_rise = ~rd_q & rd_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ibf_q <= 1'b0;
    else if (!mode_i)  ibf_q <= 1'b0;
    else if (stb_fall) ibf_q <= 1'b1;
    else if (rd_rise)  ibf_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                data_q <= '0;
    else if (mode_i && !stb_s)  data_q <= dpipe_q[STAGES-1];
  end

  assign ibf_o   = ibf_q;
  assign intr_o  = ie_i & mode_i & ibf_q & stb_s & rd_q;
  assign rdata_o = data_q;

  // R2
  full_on_low_stb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ibf_q) |-> !$past(stb_s));
  // R2
  hold_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ibf_q && stb_s) |=> $stable(data_q));
  // R9
  off_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i |=> !ibf_q);
  // R4
  in_intr_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(intr_o) |-> ibf_o);
endmodule

// File: rtl/hsk_out_path.sv
module hsk_out_path #(
  parameter int unsigned DW     = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_i,
  input  logic          ie_i,
  input  logic          ack_ni,
  input  logic          wr_ni,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] pdat_o,
  output logic          obf_no,
  output logic          intr_o
);
  logic          ack_s, ack_fall;
  logic          wr_q, wr_rise;
  logic          obf_n_q;
  logic [DW-1:0] out_q;

  hsk_sync #(.STAGES(STAGES), .RST_VAL(1'b1)) u_ack_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(ack_ni),
    .lvl_o  (ack_s),
    .fall_o (ack_fall)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_q <= 1'b1;
    else         wr_q <= wr_ni;
  end
  assign wr_rise = ~wr_q & wr_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               out_q <= '0;
    else if (mode_i && !wr_ni) out_q <= wdata_i;
  end

  // new data outranks a late acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       obf_n_q <= 1'b1;
    else if (!mode_i)  obf_n_q <= 1'b1;
    else if (wr_rise)  obf_n_q <= 1'b0;
    else if (ack_fall) obf_n_q <= 1'b1;
  end

  assign pdat_o = out_q;
  assign obf_no = obf_n_q;
  assign intr_o = ie_i & mode_i & obf_n_q & ack_s & wr_q;

  // R5
  obf_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(obf_n_q) |-> (!$past(wr_q) && wr_q));
  // R6
  obf_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(obf_n_q) |-> (!$past(ack_s) || !$past(mode_i)));
  // R9
  off_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i |=> obf_n_q);
  // R7
  busy_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !obf_no |-> !intr_o);
endmodule

// File: rtl/hsk_port.sv
module hsk_port #(
  parameter hsk_pkg::port_dir_e DIR    = hsk_pkg::DIR_IN,
  parameter int unsigned        DW     = 8,
  parameter int unsigned        STAGES = hsk_pkg::MIN_SYNC
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_i,
  input  logic          ie_we_i,
  input  logic          ie_i,
  input  logic          rd_ni,
  input  logic          wr_ni,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [DW-1:0] pdat_i,
  output logic [DW-1:0] pdat_o,
  input  logic          stb_ni,
  input  logic          ack_ni,
  output logic          ibf_o,
  output logic          obf_no,
  output logic          intr_o
);
  logic mode_q, ie_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0;
      ie_q   <= 1'b0;
    end else begin
      mode_q <= mode_i;
      if (ie_we_i) ie_q <= ie_i;
    end
  end

  if (DIR == hsk_pkg::DIR_IN) begin : g_in
    logic unused_out_side;
    assign unused_out_side = ^{wr_ni, ack_ni, wdata_i};

    hsk_in_path #(.DW(DW), .STAGES(STAGES)) u_in (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .mode_i (mode_q),
      .ie_i   (ie_q),
      .stb_ni (stb_ni),
      .rd_ni  (rd_ni),
      .pdat_i (pdat_i),
      .ibf_o  (ibf_o),
      .intr_o (intr_o),
      .rdata_o(rdata_o)
    );
    assign pdat_o = '0;
    assign obf_no = 1'b1;
  end else begin : g_out
    logic [DW-1:0] out_latch;
    logic          unused_in_side;
    assign unused_in_side = ^{rd_ni, stb_ni, pdat_i};

    hsk_out_path #(.DW(DW), .STAGES(STAGES)) u_out (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .mode_i (mode_q),
      .ie_i   (ie_q),
      .ack_ni (ack_ni),
      .wr_ni  (wr_ni),
      .wdata_i(wdata_i),
      .pdat_o (out_latch),
      .obf_no (obf_no),
      .intr_o (intr_o)
    );
    assign pdat_o  = out_latch;
    assign rdata_o = out_latch;
    assign ibf_o   = 1'b0;
  end

  // R8
  ie_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ie_we_i && !ie_i) |=> !intr_o);
endmodule

// File: tb/sim_hsk_port.sv
module sim_hsk_port;
  typedef struct packed {
    logic       mode, ie_we, ie, stb, ack, rd, wr;
    logic [7:0] pdat, wdat;
    logic       e_ibf, e_iintr;
    logic [7:0] e_idata;
    logic       e_obfn, e_ointr;
    logic [7:0] e_odata;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1, 8'h00,8'h00, 1'b0,1'b0,8'h00, 1'b1,1'b0,8'h00},
    '{1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1, 8'h00,8'h00, 1'b0,1'b0,8'h00, 1'b1,1'b1,8'h00},
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1, 8'hA5,8'h00, 1'b1,1'b0,8'hA5, 1'b1,1'b1,8'h00},
    '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1, 8'h3C,8'h00, 1'b1,1'b1,8'hA5, 1'b1,1'b1,8'h00},
    '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1, 8'h3C,8'h00, 1'b1,1'b0,8'hA5, 1'b1,1'b1,8'h00},
    '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1, 8'h3C,8'h00, 1'b0,1'b0,8'hA5, 1'b1,1'b1,8'h00},
    '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0, 8'h3C,8'h5A, 1'b0,1'b0,8'hA5, 1'b1,1'b0,8'h5A},
    '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1, 8'h3C,8'h5A, 1'b0,1'b0,8'hA5, 1'b0,1'b0,8'h5A},
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1, 8'h3C,8'h5A, 1'b0,1'b0,8'hA5, 1'b1,1'b0,8'h5A},
    '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1, 8'h3C,8'h5A, 1'b0,1'b0,8'hA5, 1'b1,1'b1,8'h5A},
    '{1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,1'b1, 8'h3C,8'h5A, 1'b0,1'b0,8'hA5, 1'b1,1'b0,8'h5A},
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1, 8'h11,8'h5A, 1'b1,1'b0,8'h11, 1'b1,1'b0,8'h5A},
    '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1, 8'h11,8'h5A, 1'b1,1'b0,8'h11, 1'b1,1'b0,8'h5A},
    '{1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1, 8'h11,8'h5A, 1'b1,1'b1,8'h11, 1'b1,1'b1,8'h5A},
    '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1, 8'h11,8'h5A, 1'b0,1'b0,8'h11, 1'b1,1'b0,8'h5A},
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1, 8'h22,8'h5A, 1'b0,1'b0,8'h11, 1'b1,1'b0,8'h5A},
    '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0, 8'h22,8'h99, 1'b0,1'b0,8'h11, 1'b1,1'b0,8'h5A},
    '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0, 8'h22,8'h77, 1'b0,1'b0,8'h11, 1'b1,1'b0,8'h77},
    '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1, 8'h22,8'h77, 1'b0,1'b0,8'h11, 1'b0,1'b0,8'h77},
    '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1, 8'h22,8'h77, 1'b0,1'b0,8'h11, 1'b1,1'b0,8'h77},
    '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1, 8'h22,8'h77, 1'b0,1'b0,8'h11, 1'b1,1'b1,8'h77}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode = 1'b0, ie_we = 1'b0, ie = 1'b0;
  logic       stb_n = 1'b1, ack_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] pdat = 8'h00, wdat = 8'h00;
  logic [7:0] i_rdata, i_pdat_o, o_rdata, o_pdat_o;
  logic       i_ibf, i_obfn, i_intr, o_ibf, o_obfn, o_intr;
  int         total = 0, bad = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  hsk_port #(.DIR(hsk_pkg::DIR_IN)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .ie_we_i(ie_we), .ie_i(ie),
    .rd_ni(rd_n), .wr_ni(wr_n), .wdata_i(wdat), .rdata_o(i_rdata),
    .pdat_i(pdat), .pdat_o(i_pdat_o), .stb_ni(stb_n), .ack_ni(ack_n),
    .ibf_o(i_ibf), .obf_no(i_obfn), .intr_o(i_intr));

  hsk_port #(.DIR(hsk_pkg::DIR_OUT)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .ie_we_i(ie_we), .ie_i(ie),
    .rd_ni(rd_n), .wr_ni(wr_n), .wdata_i(wdat), .rdata_o(o_rdata),
    .pdat_i(pdat), .pdat_o(o_pdat_o), .stb_ni(stb_n), .ack_ni(ack_n),
    .ibf_o(o_ibf), .obf_no(o_obfn), .intr_o(o_intr));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(2);
    // R1 reset state
    chk("R1 ibf", {7'd0, i_ibf}, 8'h00);
    chk("R1 obf_n", {7'd0, o_obfn}, 8'h01);
    chk("R1 intr in", {7'd0, i_intr}, 8'h00);
    chk("R1 intr out", {7'd0, o_intr}, 8'h00);
    chk("R1 rdata in", i_rdata, 8'h00);
    chk("R1 pdat out", o_pdat_o, 8'h00);
    rst_n = 1'b1;
    tick(2);

    // vector walk: R2 R3 R4 R5 R6 R7 R8 R9
    for (int v = 0; v < NV; v++) begin
      mode = VEC[v].mode; ie_we = VEC[v].ie_we; ie = VEC[v].ie;
      stb_n = VEC[v].stb; ack_n = VEC[v].ack; rd_n = VEC[v].rd; wr_n = VEC[v].wr;
      pdat = VEC[v].pdat; wdat = VEC[v].wdat;
      tick(4);
      chk($sformatf("R2/R3 ibf v%0d", v), {7'd0, i_ibf}, {7'd0, VEC[v].e_ibf});
      chk($sformatf("R4/R8 in intr v%0d", v), {7'd0, i_intr}, {7'd0, VEC[v].e_iintr});
      chk($sformatf("R2/R9 rdata v%0d", v), i_rdata, VEC[v].e_idata);
      chk($sformatf("R5/R6 obf_n v%0d", v), {7'd0, o_obfn}, {7'd0, VEC[v].e_obfn});
      chk($sformatf("R7/R8 out intr v%0d", v), {7'd0, o_intr}, {7'd0, VEC[v].e_ointr});
      chk($sformatf("R5/R9 pdat_o v%0d", v), o_pdat_o, VEC[v].e_odata);
      chk($sformatf("R10 readback v%0d", v), o_rdata, VEC[v].e_odata);
    end
    ie_we = 1'b0;

    // R10 direction tie-offs
    chk("R10 in pdat_o", i_pdat_o, 8'h00);
    chk("R10 in obf_n", {7'd0, i_obfn}, 8'h01);
    chk("R10 out ibf", {7'd0, o_ibf}, 8'h00);

    // R2 exact latency
    stb_n = 1'b0; pdat = 8'hC3;
    tick(2);
    chk("R2 ibf early", {7'd0, i_ibf}, 8'h00);
    tick(1);
    chk("R2 ibf due", {7'd0, i_ibf}, 8'h01);
    stb_n = 1'b1;
    tick(1);
    chk("R4 intr early", {7'd0, i_intr}, 8'h00);
    tick(1);
    chk("R4 intr due", {7'd0, i_intr}, 8'h01);
    chk("R2 data", i_rdata, 8'hC3);
    rd_n = 1'b0;
    tick(1);
    chk("R4 intr drop on read", {7'd0, i_intr}, 8'h00);
    chk("R3 ibf held while read low", {7'd0, i_ibf}, 8'h01);
    rd_n = 1'b1;
    tick(1);
    chk("R3 ibf clear on read rise", {7'd0, i_ibf}, 8'h00);

    // R3 strobe fall coincides with read rise
    stb_n = 1'b0; pdat = 8'h4B; tick(4);
    stb_n = 1'b1; tick(4);
    rd_n = 1'b0; tick(2);
    stb_n = 1'b0; pdat = 8'h6D;
    tick(2);
    rd_n = 1'b1;
    tick(1);
    chk("R3 set wins", {7'd0, i_ibf}, 8'h01);
    stb_n = 1'b1; tick(4);
    chk("R2 data second", i_rdata, 8'h6D);
    chk("R4 intr after coincide", {7'd0, i_intr}, 8'h01);
    rd_n = 1'b0; tick(1); rd_n = 1'b1; tick(2);

    // R6 acknowledge fall coincides with write rise
    wr_n = 1'b0; wdat = 8'hE7; tick(2);
    ack_n = 1'b0;
    tick(2);
    wr_n = 1'b1;
    tick(1);
    chk("R6 write wins", {7'd0, o_obfn}, 8'h00);
    ack_n = 1'b1; tick(4);
    chk("R7 busy no intr", {7'd0, o_intr}, 8'h00);
    chk("R5 data out", o_pdat_o, 8'hE7);
    ack_n = 1'b0;
    tick(2);
    chk("R6 obf early", {7'd0, o_obfn}, 8'h00);
    tick(1);
    chk("R6 obf due", {7'd0, o_obfn}, 8'h01);
    ack_n = 1'b1; tick(4);
    chk("R7 intr after ack", {7'd0, o_intr}, 8'h01);

    // R8 clearing the enable drops the interrupt one edge later
    ie_we = 1'b1; ie = 1'b0;
    tick(1);
    chk("R8 intr cleared", {7'd0, o_intr}, 8'h00);
    ie_we = 1'b0;
    tick(1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule